// File: doc/BRIEF.md
# Bridge Configuration Register Slice

This block holds a small part of a bus bridge's configuration space: a 32-bit subsystem identifier, an 8-bit capability pointer and a power-management I/O base. Accesses arrive one dword at a time on a valid/ready request channel. Each request carries a dword index, four byte enables, a write flag and write data. Every accepted request produces exactly one response beat on a valid/ready response channel. The response carries read data and a flag that marks an access no register in this slice claims.

The subsystem identifier can be written only once. The first write after reset that has any byte enable set locks it, and the lock holds until the next platform reset. The I/O base places a 128-byte window on a 128-byte boundary anywhere in the 16-bit I/O space. A combinational comparator flags every incoming I/O address that falls inside the window.

Back-pressure rules:
- A request is accepted in a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is high only when the response slot is empty or is being drained in that same cycle.
- While `rsp_valid` is high and `rsp_ready` is low, the response beat holds every field unchanged.

Top module: `bridge_cfg_slice`

## Requirements
- R1: After reset, reading dword 0x0B (subsystem identifier) returns 0x00000000. Reading dword 0x10 (I/O base) returns 0x00000001. Reading dword 0x0D (capability pointer) returns 0x000000E0.
- R2: The first write to dword 0x0B after reset that has at least one byte enable set stores only its enabled bytes, with byte enable n controlling data bits 8n+7:8n. A write with all byte enables clear stores nothing and does not lock the register.
- R3: Once the subsystem identifier has been locked, every later write to dword 0x0B is ignored until the next reset.
- R4: Dword 0x0D always reads 0x000000E0. Writes to it have no effect.
- R5: In dword 0x10, bits 15:7 are writable: bit 7 is taken from byte lane 0 and bits 15:8 from byte lane 1. Bits 31:16 and 6:1 read 0 and ignore writes. Bit 0 always reads 1.
- R6: `io_hit` is high exactly when `io_addr[15:7]` equals base bits 15:7. The comparison is combinational. A base write accepted at a clock edge changes `io_hit` right after that edge and not before it.
- R7: An access to any dword index other than 0x0B, 0x0D and 0x10 returns read data 0x00000000 with `rsp_unclaimed` high. Accesses to those three indices have `rsp_unclaimed` low.
- R8: Each accepted request yields one response beat, one cycle after acceptance, in request order. Write responses carry read data 0x00000000. `req_ready` is low while a response is stalled, and a stalled response holds its data and flag stable.
- R9: Reset clears the write-once lock. The first write after reset is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Platform reset, active low |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Dword index into configuration space |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_unclaimed | output | 1 | Access hit no register in this slice |
| io_addr | input | 16 | I/O address to decode |
| io_hit | output | 1 | I/O address is inside the base window |

## Verification
The I/O window decode and a write to the base register can fall in the same cycle. The bench holds `io_addr` inside the window that the pending base write will create and lets the write be accepted at the next edge. It then samples `io_hit` twice: before that edge, where the old base must still rule, and after it, where the new base must. Response back-pressure is a second overlap. The consumer stalls `rsp_ready` on a fixed pattern while requests keep arriving. The scoreboard must then see every response, in order and unchanged.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int CFG_DW_W = 6;
  localparam logic [CFG_DW_W-1:0] DW_SSID   = 6'h0B;
  localparam logic [CFG_DW_W-1:0] DW_CAPP   = 6'h0D;
  localparam logic [CFG_DW_W-1:0] DW_PMBASE = 6'h10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SSID,
    SEL_CAPP,
    SEL_PMB
  } reg_sel_e;

  typedef struct packed {
    logic [31:0] rdata;
    logic        unclaimed;
  } cfg_rsp_t;
endpackage

// File: rtl/bcs_ssid_reg.sv
module bcs_ssid_reg #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   value
);
  localparam int LANES = DATA_W / 8;

  logic locked_q;
  logic take;

  // A write claims the register only when some lane is enabled.
  assign take = wr_en && !locked_q && (|be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else if (take) begin
      locked_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        value[8*g +: 8] <= 8'h00;
      end else if (take && be[g]) begin
        value[8*g +: 8] <= wdata[8*g +: 8];
      end
    end
  end
endmodule

// File: rtl/bcs_pmbase_reg.sv
module bcs_pmbase_reg #(
  parameter int IO_W    = 16,
  parameter int WIN_LSB = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [IO_W-1:WIN_LSB] base,
  output logic [31:0]       word
);
  // Each writable bit follows the byte lane that carries it.
  for (genvar i = WIN_LSB; i < IO_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base[i] <= 1'b0;
      end else if (wr_en && be[i/8]) begin
        base[i] <= wdata[i];
      end
    end
  end

  always_comb begin
    word                 = '0;
    word[IO_W-1:WIN_LSB] = base;
    word[0]              = 1'b1;
  end
endmodule

// File: rtl/bcs_io_decode.sv
module bcs_io_decode #(
  parameter int IO_W    = 16,
  parameter int WIN_LSB = 7
) (
  input  logic [IO_W-1:0]       io_addr,
  input  logic [IO_W-1:WIN_LSB] base,
  output logic                  hit
);
  assign hit = (io_addr[IO_W-1:WIN_LSB] == base);
endmodule

// File: rtl/bridge_cfg_slice.sv
module bridge_cfg_slice
  import bcs_pkg::*;
#(
  parameter int         ADDR_W  = CFG_DW_W,
  parameter int         IO_W    = 16,
  parameter int         WIN_LSB = 7,
  parameter logic [7:0] CAP_PTR = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_unclaimed,
  input  logic [IO_W-1:0]   io_addr,
  output logic              io_hit
);
  logic                  accept;
  reg_sel_e              sel;
  logic [31:0]           ssid_val;
  logic [31:0]           pm_word;
  logic [IO_W-1:WIN_LSB] pm_base;
  logic [31:0]           rd_mux;
  cfg_rsp_t              rsp_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    unique case (req_addr)
      DW_SSID:   sel = SEL_SSID;
      DW_CAPP:   sel = SEL_CAPP;
      DW_PMBASE: sel = SEL_PMB;
      default:   sel = SEL_NONE;
    endcase
  end

  bcs_ssid_reg #(.DATA_W(32)) u_ssid (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept && req_write && (sel == SEL_SSID)),
    .be    (req_be),
    .wdata (req_wdata),
    .value (ssid_val)
  );

  bcs_pmbase_reg #(.IO_W(IO_W), .WIN_LSB(WIN_LSB)) u_pmbase (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept && req_write && (sel == SEL_PMB)),
    .be    (req_be),
    .wdata (req_wdata),
    .base  (pm_base),
    .word  (pm_word)
  );

  bcs_io_decode #(.IO_W(IO_W), .WIN_LSB(WIN_LSB)) u_dec (
    .io_addr (io_addr),
    .base    (pm_base),
    .hit     (io_hit)
  );

  always_comb begin
    unique case (sel)
      SEL_SSID: rd_mux = ssid_val;
      SEL_CAPP: rd_mux = {24'h0, CAP_PTR};
      SEL_PMB:  rd_mux = pm_word;
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= '0;
    end else if (accept) begin
      rsp_valid       <= 1'b1;
      rsp_q.rdata     <= req_write ? 32'h0 : rd_mux;
      rsp_q.unclaimed <= (sel == SEL_NONE);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_rdata     = rsp_q.rdata;
  assign rsp_unclaimed = rsp_q.unclaimed;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int ADDR_W  = CFG_DW_W,
  parameter int IO_W    = 16,
  parameter int WIN_LSB = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_unclaimed,
  input logic [IO_W-1:0]   io_addr,
  input logic              io_hit,
  input logic [31:0]       ssid_val,
  input logic [31:0]       pm_word
);
  logic lock_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_seen <= 1'b0;
    else if (req_valid && req_ready && req_write && req_addr == DW_SSID && (|req_be))
      lock_seen <= 1'b1;
  end

  a_r3_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    lock_seen |=> $stable(ssid_val));

  a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_word[31:IO_W] == '0) && (pm_word[WIN_LSB-1:0] == 1));

  a_r6_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_addr[IO_W-1:WIN_LSB] == pm_word[IO_W-1:WIN_LSB]));

  a_r7_unclaimed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unclaimed) |-> (rsp_rdata == 32'h0));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_unclaimed)));

  a_r8_no_accept_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind bridge_cfg_slice bcs_checker #(
  .ADDR_W(ADDR_W), .IO_W(IO_W), .WIN_LSB(WIN_LSB)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_unclaimed(rsp_unclaimed), .io_addr(io_addr), .io_hit(io_hit),
  .ssid_val(ssid_val), .pm_word(pm_word)
);

// File: tb/bridge_cfg_slice_tb_top.sv
module bridge_cfg_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_unclaimed;
  logic [15:0] io_addr = '0;
  logic        io_hit;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  typedef struct {
    logic [31:0] d;
    bit          u;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  bridge_cfg_slice dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_unclaimed(rsp_unclaimed),
    .io_addr(io_addr), .io_hit(io_hit)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // Consumer back-pressure pattern
  always @(posedge clk) begin
    cyc++;
    #1;
    rsp_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
  end

  // Monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected response", rsp_rdata, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_rdata === e.d, {e.tag, " rdata"}, rsp_rdata, e.d);
        chk(rsp_unclaimed === e.u, {e.tag, " unclaimed"},
            {31'h0, rsp_unclaimed}, {31'h0, e.u});
      end
    end
  end

  task automatic access(input bit wr, input logic [5:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic [31:0] er, input bit eu,
                        input string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    exp_q.push_back('{er, eu, tag});
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
    chk(req_ready == 1'b1, "R8 req_ready idle", {31'h0, req_ready}, 32'h1);

    // R1 reset values
    access(0, 6'h0B, 4'hF, 0, 32'h0000_0000, 0, "R1 ssid reset");
    access(0, 6'h10, 4'hF, 0, 32'h0000_0001, 0, "R1 base reset");
    access(0, 6'h0D, 4'hF, 0, 32'h0000_00E0, 0, "R1 capp reset");
    drain();
    io_addr = 16'h0040; #1;
    chk(io_hit == 1'b1, "R6 reset window hit", {31'h0, io_hit}, 32'h1);
    io_addr = 16'h0080; #1;
    chk(io_hit == 1'b0, "R6 reset window miss", {31'h0, io_hit}, 32'h0);

    // R2 write-once
    access(1, 6'h0B, 4'h0, 32'hFFFF_FFFF, 0, 0, "R2 no-lane write");
    access(0, 6'h0B, 4'hF, 0, 32'h0000_0000, 0, "R2 no-lane left zero");
    access(1, 6'h0B, 4'b0101, 32'h1122_3344, 0, 0, "R2 first write");
    access(0, 6'h0B, 4'hF, 0, 32'h0022_0044, 0, "R2 lanes stored");
    access(1, 6'h0B, 4'hF, 32'hAABB_CCDD, 0, 0, "R3 late write");
    access(0, 6'h0B, 4'hF, 0, 32'h0022_0044, 0, "R3 ignored");

    // R4 capability pointer
    access(1, 6'h0D, 4'hF, 32'hFFFF_FFFF, 0, 0, "R4 capp write");
    access(0, 6'h0D, 4'hF, 0, 32'h0000_00E0, 0, "R4 capp unchanged");

    // R5 base field layout
    access(1, 6'h10, 4'hF, 32'hFFFF_FFFF, 0, 0, "R5 base all ones");
    access(0, 6'h10, 4'hF, 0, 32'h0000_FF81, 0, "R5 base masked");
    access(1, 6'h10, 4'b0001, 32'h0000_0000, 0, 0, "R5 lane0 write");
    access(0, 6'h10, 4'hF, 0, 32'h0000_FF01, 0, "R5 bit7 from lane0");
    access(1, 6'h10, 4'b0010, 32'h0000_1200, 0, 0, "R5 lane1 write");
    access(0, 6'h10, 4'hF, 0, 32'h0000_1201, 0, "R5 high from lane1");
    drain();
    io_addr = 16'h1200; #1;
    chk(io_hit == 1'b1, "R6 window low edge", {31'h0, io_hit}, 32'h1);
    io_addr = 16'h127F; #1;
    chk(io_hit == 1'b1, "R6 window high edge", {31'h0, io_hit}, 32'h1);
    io_addr = 16'h1280; #1;
    chk(io_hit == 1'b0, "R6 above window", {31'h0, io_hit}, 32'h0);
    io_addr = 16'h11FF; #1;
    chk(io_hit == 1'b0, "R6 below window", {31'h0, io_hit}, 32'h0);

    // R6 decode and base write in the same cycle
    io_addr = 16'h3410;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h10; req_be = 4'b0011;
    req_wdata = 32'h0000_3400;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before base write", {31'h0, req_ready}, 32'h1);
    chk(io_hit == 1'b0, "R6 old base before edge", {31'h0, io_hit}, 32'h0);
    exp_q.push_back('{32'h0, 1'b0, "R6 base write rsp"});
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(io_hit == 1'b1, "R6 new base after edge", {31'h0, io_hit}, 32'h1);

    // R7 unclaimed
    access(0, 6'h00, 4'hF, 0, 32'h0, 1, "R7 dword 0");
    access(0, 6'h0C, 4'hF, 0, 32'h0, 1, "R7 dword 0x0C");
    access(1, 6'h14, 4'hF, 32'hDEAD_BEEF, 32'h0, 1, "R7 write unclaimed");

    // R8 ordering under back-pressure
    bp_on = 1'b1;
    for (int k = 0; k < 6; k++) begin
      access(0, 6'h0D, 4'hF, 0, 32'h0000_00E0, 0, "R8 bp capp");
      access(0, 6'h10, 4'hF, 0, 32'h0000_3401, 0, "R8 bp base");
      access(0, 6'h3F, 4'hF, 0, 32'h0, 1, "R8 bp unclaimed");
    end
    drain();
    bp_on = 1'b0;

    // R9 reset reopens the lock
    do_reset();
    access(0, 6'h0B, 4'hF, 0, 32'h0, 0, "R9 ssid cleared");
    access(0, 6'h10, 4'hF, 0, 32'h0000_0001, 0, "R9 base cleared");
    access(1, 6'h0B, 4'hF, 32'h1234_5678, 0, 0, "R9 write after reset");
    access(0, 6'h0B, 4'hF, 0, 32'h1234_5678, 0, "R9 stored after reset");
    access(1, 6'h0B, 4'hF, 32'h0, 0, 0, "R3 relocked write");
    access(0, 6'h0B, 4'hF, 0, 32'h1234_5678, 0, "R3 relocked");
    drain();

    report();
    $finish;
  end
endmodule